// File: doc/BRIEF.md
# Trace Data Buffer and Nibble Serializer

This block sits between a processor core's debug logic and a narrow 4-bit trace data port. The core hands it payloads: either the target address of a taken branch or an operand written by a debug-write instruction. Each payload carries a byte count of one to four. The block holds payloads in a two-entry, 32-bit-wide queue and sends each one out one nibble per clock, least significant nibble first. An entry therefore takes 2, 4, 6 or 8 cycles on the port.

One cycle before a payload's first nibble, the block raises a marker request carrying the byte count. A separate status encoder uses it to announce the transfer on the status port. The marker for the next payload may share a cycle with the last nibble of the current one, so consecutive payloads stream with no gap. When both queue entries are occupied, the block asserts a stall to the core. It releases the stall in the cycle after an entry leaves.

The byte count is chosen inside the block. For an operand it follows the operand size. For a branch target it comes from a configuration field supplied by the debug control register.

Top module: `trace_nib_port`

## Requirements
- R1: After reset, `stall_o`, `marker_valid_o` and `nib_valid_o` are 0 and `nib_o` is 0x0.
- R2: For an operand payload (`push_src_i` = 0), the byte count follows `push_opsz_i`. 00 (byte) gives 1 byte, 01 (word) gives 2 bytes, and 10 (longword) gives 4 bytes. The reserved code 11 also gives 4 bytes.
- R3: For a branch payload (`push_src_i` = 1), the byte count is `cfg_br_len_i` + 1, and `push_opsz_i` is ignored.
- R4: For every payload, `marker_valid_o` is high for exactly one cycle, the cycle immediately before its first nibble. In that cycle `marker_len_o` equals the byte count minus 1.
- R5: A payload of N bytes drives `nib_valid_o` high for 2N consecutive cycles. In cycle k, counted from 0, `nib_o` carries bits [4k+3:4k] of the payload.
- R6: In any cycle without a nibble, `nib_valid_o` is 0 and `nib_o` is 0x0.
- R7: `stall_o` is high exactly while both entries hold a payload that has not yet started on the port. A push presented while `stall_o` is high is discarded and never appears on the port.
- R8: When a payload leaves a full queue, `stall_o` falls in the following cycle.
- R9: Payloads leave in arrival order. The next payload's marker coincides with the previous payload's last nibble, so nibbles of queued payloads follow each other without idle cycles.
- R10: A push accepted in the same cycle as a payload leaves the queue is kept; it is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid_i | input | 1 | Core offers a payload this cycle (taken only when `stall_o` is 0) |
| push_src_i | input | 1 | Payload kind: 0 operand, 1 branch target |
| push_opsz_i | input | 2 | Operand size: 00 byte, 01 word, 10 longword, 11 reserved (longword) |
| cfg_br_len_i | input | 2 | Branch target byte count minus 1, from the debug control register |
| push_data_i | input | 32 | Payload value, low bytes significant |
| stall_o | output | 1 | Both entries occupied; the core must hold |
| marker_valid_o | output | 1 | Byte-count marker request, one cycle ahead of data |
| marker_len_o | output | 2 | Byte count minus 1 for the marker |
| nib_valid_o | output | 1 | A trace nibble is on `nib_o` |
| nib_o | output | 4 | Trace data nibble, 0x0 when idle |

## Verification
Several properties are checked on every cycle, whatever the stimulus. The idle-zero rule holds at all times. A marker is always followed by data and never lasts two cycles. A nibble stream never starts without a marker just before it. A full queue stays full with no departure and frees in the cycle after one. Other properties depend on the payload values, so only the directed scenarios can show them. These are the length each operand size or branch setting produces, the exact nibble order within a payload, arrival-order draining across back-to-back payloads, and the disappearance of a push made during a stall.

// File: rtl/trace_pkg.sv
// trace_pkg: shared types and length decoding helpers for the trace data port.
// Assumes payloads of at most four bytes, so a length code is two bits (bytes - 1).
package trace_pkg;

    typedef enum logic {
        SRC_OPERAND = 1'b0,
        SRC_BRANCH  = 1'b1
    } trace_src_e;

    typedef enum logic [1:0] {
        OPSZ_BYTE = 2'b00,
        OPSZ_WORD = 2'b01,
        OPSZ_LONG = 2'b10,
        OPSZ_RSVD = 2'b11
    } trace_opsz_e;

    // Length code (bytes - 1) for an operand of the given size; reserved maps to longword.
    function automatic logic [1:0] opsz_to_len(trace_opsz_e sz);
        logic [1:0] code;
        case (sz)
            OPSZ_BYTE: code = 2'd0;
            OPSZ_WORD: code = 2'd1;
            default:   code = 2'd3;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/trace_len_sel.sv
// trace_len_sel: picks the byte-count code of an incoming payload.
// Operands take their count from the operand size; branch targets take it from the
// configuration field. Purely combinational; assumes LEN_W = 2 (up to four bytes).
module trace_len_sel
    import trace_pkg::*;
#(
    parameter int unsigned LEN_W = 2
) (
    input  logic             src_i,
    input  logic [1:0]       opsz_i,
    input  logic [LEN_W-1:0] cfg_br_len_i,
    output logic [LEN_W-1:0] len_o
);

    // Select the length source by payload kind.
    always_comb begin
        if (trace_src_e'(src_i) == SRC_BRANCH) begin
            len_o = cfg_br_len_i;
        end else begin
            len_o = LEN_W'(opsz_to_len(trace_opsz_e'(opsz_i)));
        end
    end

endmodule

// File: rtl/trace_fifo.sv
// trace_fifo: small circular queue of payloads with their length codes.
// A push is taken only when not full; a pop only when not empty. Push and pop may
// happen in one cycle. full_o reflects occupancy before the cycle's pop.
module trace_fifo #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LEN_W  = 2,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic [LEN_W-1:0]  push_len_i,
    input  logic              pop_i,
    output logic              head_valid_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic [LEN_W-1:0]  head_len_o,
    output logic              full_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] data_q [DEPTH];
    logic [LEN_W-1:0]  len_q  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              push_ok, pop_ok;

    // Gate requests by occupancy.
    always_comb begin
        push_ok = push_i && (count_q != CNT_FULL);
        pop_ok  = pop_i && (count_q != '0);
    end

    // One storage slot per entry, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g] <= '0;
                len_q[g]  <= '0;
            end else if (push_ok && (wr_ptr_q == PTR_W'(g))) begin
                data_q[g] <= push_data_i;
                len_q[g]  <= push_len_i;
            end
        end
    end

    // Advance pointers with wrap-around and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Present the oldest entry and the full flag.
    always_comb begin
        head_valid_o = (count_q != '0);
        head_data_o  = data_q[rd_ptr_q];
        head_len_o   = len_q[rd_ptr_q];
        full_o       = (count_q == CNT_FULL);
    end

endmodule

// File: rtl/trace_nib_ser.sv
// trace_nib_ser: shifts one payload at a time onto the nibble port, lsb first.
// It takes the queue head when idle or while sending its last nibble. In that
// same cycle it raises the marker, so the marker precedes the first nibble by one cycle.
// Assumes DATA_W/NIB_W = 2^(LEN_W+1), i.e. a full-length payload fills the shifter.
module trace_nib_ser #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NIB_W  = 4,
    parameter int unsigned LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid_i,
    input  logic [DATA_W-1:0] head_data_i,
    input  logic [LEN_W-1:0]  head_len_i,
    output logic              pop_o,
    output logic              marker_valid_o,
    output logic [LEN_W-1:0]  marker_len_o,
    output logic              nib_valid_o,
    output logic [NIB_W-1:0]  nib_o
);

    localparam int unsigned NIBS  = DATA_W / NIB_W;
    localparam int unsigned CNT_W = $clog2(NIBS);

    logic              busy_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  remain_q;
    logic              last_nib, load;

    // Decide when the current payload ends and the next one is taken.
    always_comb begin
        last_nib = busy_q && (remain_q == '0);
        load     = head_valid_i && (!busy_q || last_nib);
    end

    // Load a payload or shift out one nibble per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            shreg_q  <= '0;
            remain_q <= '0;
        end else if (load) begin
            busy_q   <= 1'b1;
            shreg_q  <= head_data_i;
            remain_q <= CNT_W'({head_len_i, 1'b1});
        end else if (busy_q) begin
            shreg_q  <= shreg_q >> NIB_W;
            remain_q <= remain_q - 1'b1;
            if (last_nib) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Drive the port; the nibble lane is forced to zero while idle.
    always_comb begin
        pop_o          = load;
        marker_valid_o = load;
        marker_len_o   = head_len_i;
        nib_valid_o    = busy_q;
        nib_o          = busy_q ? shreg_q[NIB_W-1:0] : '0;
    end

endmodule

// File: rtl/trace_nib_port.sv
// trace_nib_port: top of the trace data path. Decodes the byte count of each
// payload, queues it, and streams it as nibbles with a one-cycle-ahead marker.
// The core must hold its request while stall_o is high; a push offered then is dropped.
module trace_nib_port #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NIB_W  = 4,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid_i,
    input  logic              push_src_i,
    input  logic [1:0]        push_opsz_i,
    input  logic [1:0]        cfg_br_len_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic              stall_o,
    output logic              marker_valid_o,
    output logic [1:0]        marker_len_o,
    output logic              nib_valid_o,
    output logic [NIB_W-1:0]  nib_o
);

    localparam int unsigned LEN_W = 2;

    logic [LEN_W-1:0]  in_len;
    logic              full, pop, head_valid;
    logic [DATA_W-1:0] head_data;
    logic [LEN_W-1:0]  head_len;
    logic              push_take;

    // Accept a push only while the queue has room.
    always_comb begin
        push_take = push_valid_i && !full;
        stall_o   = full;
    end

    trace_len_sel #(.LEN_W(LEN_W)) u_len (
        .src_i       (push_src_i),
        .opsz_i      (push_opsz_i),
        .cfg_br_len_i(cfg_br_len_i),
        .len_o       (in_len)
    );

    trace_fifo #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_take),
        .push_data_i (push_data_i),
        .push_len_i  (in_len),
        .pop_i       (pop),
        .head_valid_o(head_valid),
        .head_data_o (head_data),
        .head_len_o  (head_len),
        .full_o      (full)
    );

    trace_nib_ser #(.DATA_W(DATA_W), .NIB_W(NIB_W), .LEN_W(LEN_W)) u_ser (
        .clk           (clk),
        .rst_n         (rst_n),
        .head_valid_i  (head_valid),
        .head_data_i   (head_data),
        .head_len_i    (head_len),
        .pop_o         (pop),
        .marker_valid_o(marker_valid_o),
        .marker_len_o  (marker_len_o),
        .nib_valid_o   (nib_valid_o),
        .nib_o         (nib_o)
    );

endmodule

// File: rtl/trace_nib_port_chk.sv
// trace_nib_port_chk: cycle-by-cycle protocol checks on the trace port outputs.
// Assumes it is bound to trace_nib_port and sees only its ports.
module trace_nib_port_chk #(
    parameter int unsigned NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall_o,
    input logic             marker_valid_o,
    input logic             nib_valid_o,
    input logic [NIB_W-1:0] nib_o
);

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !nib_valid_o |-> (nib_o == '0));

    assert_marker_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        marker_valid_o |=> nib_valid_o);

    assert_marker_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        marker_valid_o |=> !marker_valid_o);

    assert_stream_after_marker_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nib_valid_o) |-> $past(marker_valid_o));

    assert_stall_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && marker_valid_o) |=> !stall_o);

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !marker_valid_o) |=> stall_o);

endmodule

bind trace_nib_port trace_nib_port_chk #(.NIB_W(NIB_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_o       (stall_o),
    .marker_valid_o(marker_valid_o),
    .nib_valid_o   (nib_valid_o),
    .nib_o         (nib_o)
);

// File: tb/sim_trace_nib_port.sv
// sim_trace_nib_port: directed scenarios for the trace nibble port, one task each.
module sim_trace_nib_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid_i = 1'b0;
    logic        push_src_i = 1'b0;
    logic [1:0]  push_opsz_i = 2'b00;
    logic [1:0]  cfg_br_len_i = 2'b00;
    logic [31:0] push_data_i = '0;
    logic        stall_o, marker_valid_o, nib_valid_o;
    logic [1:0]  marker_len_o;
    logic [3:0]  nib_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    trace_nib_port u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_valid_i  (push_valid_i),
        .push_src_i    (push_src_i),
        .push_opsz_i   (push_opsz_i),
        .cfg_br_len_i  (cfg_br_len_i),
        .push_data_i   (push_data_i),
        .stall_o       (stall_o),
        .marker_valid_o(marker_valid_o),
        .marker_len_o  (marker_len_o),
        .nib_valid_o   (nib_valid_o),
        .nib_o         (nib_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_push(input logic src, input logic [1:0] opsz,
                              input logic [1:0] brl, input logic [31:0] data);
        push_valid_i = 1'b1;
        push_src_i   = src;
        push_opsz_i  = opsz;
        cfg_br_len_i = brl;
        push_data_i  = data;
    endtask

    task automatic drive_idle();
        push_valid_i = 1'b0;
        push_data_i  = '0;
    endtask

    // R1: outputs after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        drive_idle();
        repeat (3) @(negedge clk);
        check("R1", "stall", 32'(stall_o), 0);
        check("R1", "marker", 32'(marker_valid_o), 0);
        check("R1", "nib_valid", 32'(nib_valid_o), 0);
        check("R1", "nib", 32'(nib_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One isolated payload: marker, 2*bytes nibbles lsb first, then idle (R4, R5, R6).
    task automatic t_single(input string req, input logic src, input logic [1:0] opsz,
                            input logic [1:0] brl, input logic [31:0] data,
                            input int bytes);
        drive_push(src, opsz, brl, data);
        @(negedge clk);
        drive_idle();
        check(req, "marker valid", 32'(marker_valid_o), 1);
        check(req, "marker len", 32'(marker_len_o), 32'(bytes - 1));
        check("R4", "no data with first marker", 32'(nib_valid_o), 0);
        for (int k = 0; k < 2 * bytes; k++) begin
            @(negedge clk);
            check("R5", "nib valid", 32'(nib_valid_o), 1);
            check("R5", "nib value", 32'(nib_o), (data >> (4 * k)) & 32'hF);
            check("R4", "marker quiet", 32'(marker_valid_o), 0);
        end
        @(negedge clk);
        check("R6", "idle valid", 32'(nib_valid_o), 0);
        check("R6", "idle nib", 32'(nib_o), 0);
        @(negedge clk);
    endtask

    // Back-to-back A, B, C with stall, plus a push D dropped during the stall (R7-R10).
    task automatic t_stream();
        logic        exp_v [16];
        logic [3:0]  exp_n [16];
        logic        exp_m [16];
        logic [1:0]  exp_c [16];
        logic        exp_s [16];
        logic [31:0] pd [3];
        int          pb [3];
        int          t;
        pd[0] = 32'h0000_00E1; pb[0] = 1;   // operand byte
        pd[1] = 32'h0000_9A2B; pb[1] = 2;   // operand word
        pd[2] = 32'h00D8_C7B6; pb[2] = 3;   // branch, cfg 2 -> 3 bytes
        for (int i = 0; i < 16; i++) begin
            exp_v[i] = 1'b0; exp_n[i] = '0; exp_m[i] = 1'b0; exp_c[i] = '0; exp_s[i] = 1'b0;
        end
        exp_s[2] = 1'b1;
        t = 0;
        for (int p = 0; p < 3; p++) begin
            exp_m[t] = 1'b1;
            exp_c[t] = 2'(pb[p] - 1);
            for (int k = 0; k < 2 * pb[p]; k++) begin
                t++;
                exp_v[t] = 1'b1;
                exp_n[t] = 4'((pd[p] >> (4 * k)) & 32'hF);
            end
        end
        drive_push(1'b0, 2'b00, 2'b00, pd[0]);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check("R9", $sformatf("valid @%0d", i), 32'(nib_valid_o), 32'(exp_v[i]));
            check("R9", $sformatf("nib @%0d", i), 32'(nib_o), 32'(exp_n[i]));
            check("R9", $sformatf("marker @%0d", i), 32'(marker_valid_o), 32'(exp_m[i]));
            if (exp_m[i]) begin
                check("R4", $sformatf("marker len @%0d", i), 32'(marker_len_o), 32'(exp_c[i]));
            end
            if (i == 3) begin
                check("R8", "stall released", 32'(stall_o), 0);
            end else begin
                check("R7", $sformatf("stall @%0d", i), 32'(stall_o), 32'(exp_s[i]));
            end
            case (i)
                0: drive_push(1'b0, 2'b01, 2'b00, pd[1]);       // R10: push with pop
                1: drive_push(1'b1, 2'b11, 2'b10, pd[2]);       // R3: opsz ignored
                2: drive_push(1'b0, 2'b10, 2'b00, 32'hFFFF_FFFF); // R7: dropped
                default: drive_idle();
            endcase
        end
    endtask

    initial begin
        t_reset();
        t_single("R2", 1'b0, 2'b00, 2'b11, 32'h8765_4321, 1);
        t_single("R2", 1'b0, 2'b01, 2'b11, 32'h8765_4321, 2);
        t_single("R2", 1'b0, 2'b10, 2'b00, 32'h8765_4321, 4);
        t_single("R2", 1'b0, 2'b11, 2'b00, 32'hFEDC_BA98, 4);
        t_single("R3", 1'b1, 2'b00, 2'b00, 32'h1234_5678, 1);
        t_single("R3", 1'b1, 2'b10, 2'b01, 32'h1234_5678, 2);
        t_single("R3", 1'b1, 2'b00, 2'b10, 32'h0BAD_F00D, 3);
        t_single("R3", 1'b1, 2'b01, 2'b11, 32'hC0FF_EE42, 4);
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule